// File: doc/BRIEF.md
# Bit-String Test-and-Complement Unit

This unit carries out one test-and-complement operation at a time. It reports the chosen bit through a carry output and writes back the operand with that bit inverted. The operand is 16 or 32 bits wide. It is either a value supplied on a port (register form) or a unit in memory reached from a base byte address (memory form). The bit offset comes either from an 8-bit immediate byte or from a 32-bit register value.

In the memory form the offset may point far beyond one word. The unit splits the offset into a word index and a bit position inside that word. It scales the index into a byte displacement and adds it to the base address. It then reads and writes back the whole 2- or 4-byte unit through a simple request/acknowledge port. A destination flagged as not writable produces a protection fault instead of a write. Each form has a fixed cycle count, and memory wait states stretch it.

Top module: `bitflip_unit`

## Requirements
- R1: Carry takes the value the selected bit had before the operation. The written-back operand equals the original with exactly that bit inverted. Running the same operation twice restores the operand and toggles the reported carry.
- R2: With an immediate offset, only the offset value modulo 32 is used, so bits 5 to 7 of the byte have no effect. The bit position is offset bits [4:0] for 32-bit operands and offset bits [3:0] for 16-bit operands.
- R3: In the register form, `result` is `reg_val` with the selected bit inverted, and bits 31:16 pass through unchanged for a 16-bit operand. No memory request is raised.
- R4: For a 32-bit memory operand, `mem_addr` equals `ea + 4*floor(offset/32)`.
- R5: For a 16-bit memory operand, `mem_addr` equals `ea + 2*floor(offset/16)`.
- R6: A register offset used with a memory operand is a signed two's-complement value, so a negative offset addresses units below `ea`.
- R7: A memory operation makes exactly one read and then one write at the same address. Both carry `mem_wide`=1 for 4 bytes or 0 for 2 bytes. For a 2-byte write, `mem_wdata[31:16]` is zero, whatever the read returned there.
- R8: When `writable`=0 in the memory form, `fault` pulses together with `done`. No memory request is made, and `carry` and memory keep their old values.
- R9: Counting clock edges from the edge that samples `start` to the edge after which `done` is high, the cycle counts are as follows. The register form takes 6. The memory form takes 8 with an immediate offset and 13 with a register offset, plus one per cycle that each request waits for `mem_ack`. A faulting memory operation takes 5 (immediate) or 10 (register).
- R10: A request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_ack` is high.
- R11: `done` is a one-cycle pulse. `busy` is high from the cycle after `start` is accepted through the `done` cycle. A `start` seen while busy is ignored and launches no operation.
- R12: After reset, `busy`, `done`, `fault`, `carry` and `mem_req` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation (accepted when idle) |
| to_mem | input | 1 | 1 = memory form, 0 = register form |
| wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit |
| use_imm | input | 1 | 1 = offset from `imm_off`, 0 = from `reg_off` |
| imm_off | input | 8 | Immediate offset byte |
| reg_off | input | 32 | Register-supplied offset |
| reg_val | input | 32 | Register-form operand |
| ea | input | 32 | Base byte address of the bit string |
| writable | input | 1 | Memory destination may be written |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Pre-inversion value of the selected bit |
| fault | output | 1 | Protection fault, pulses with `done` |
| result | output | 32 | Register-form write-back value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | 1 = 4-byte access, 0 = 2-byte |
| mem_addr | output | 32 | Byte address of the unit |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ack | input | 1 | Request accepted this cycle |

## Verification
The bench targets negative register offsets whose remainder is non-zero. A design that truncates toward zero, or shifts logically, would touch the wrong unit and flip the wrong bit. It also uses immediates with bits 5 to 7 set and 16-bit offsets above 15: a design that lets those bits leak selects the wrong position or address. The bench returns junk in the upper half of a 2-byte read, which exposes a design that writes that junk back. It also pokes `start` mid-operation, stalls the acknowledge, and runs non-writable operations; these catch designs that restart, move a request before it is taken, or write or change carry on a fault.

// File: rtl/bitflip_pkg.sv
package bitflip_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_MODIFY,
    ST_WRITE,
    ST_DONE
  } bf_state_e;

  typedef struct packed {
    logic to_mem;
    logic use_imm;
    logic writable;
  } bf_mode_t;

endpackage

// File: rtl/bitflip_locate.sv
module bitflip_locate #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int POSW = $clog2(DW)
) (
  input  logic            wide,
  input  logic            use_imm,
  input  logic [7:0]      imm,
  input  logic [DW-1:0]   reg_off,
  input  logic [AW-1:0]   ea,
  output logic [POSW-1:0] bitpos,
  output logic [AW-1:0]   addr
);

  localparam int WIDE_SH = $clog2(DW / 8);
  localparam int HALF_SH = $clog2(DW / 16);

  logic [DW-1:0]        off;
  logic signed [DW-1:0] off_s;
  logic signed [DW-1:0] word_idx;
  logic signed [DW-1:0] byte_delta;

  always_comb begin
    // immediate byte reduced modulo the full operand width
    off   = use_imm ? (DW'(imm) & (DW'(DW) - DW'(1))) : reg_off;
    off_s = signed'(off);
    if (wide) begin
      bitpos     = off[POSW-1:0];
      word_idx   = off_s >>> POSW;
      byte_delta = word_idx <<< WIDE_SH;
    end else begin
      bitpos     = {1'b0, off[POSW-2:0]};
      word_idx   = off_s >>> (POSW - 1);
      byte_delta = word_idx <<< HALF_SH;
    end
    addr = ea + AW'(byte_delta);
  end

endmodule

// File: rtl/bitflip_modify.sv
module bitflip_modify #(
  parameter int DW   = 32,
  parameter int POSW = $clog2(DW)
) (
  input  logic [DW-1:0]   word,
  input  logic [POSW-1:0] bitpos,
  output logic            old_bit,
  output logic [DW-1:0]   flipped
);

  logic [DW-1:0] sel;

  for (genvar i = 0; i < DW; i++) begin : g_dec
    assign sel[i] = (bitpos == POSW'(i));
  end

  always_comb begin
    old_bit = |(word & sel);
    flipped = word ^ sel;
  end

endmodule

// File: rtl/bitflip_seq.sv
module bitflip_seq
  import bitflip_pkg::*;
#(
  parameter int PADW     = 4,
  parameter int PAD_REG  = 5,
  parameter int PAD_MIMM = 4,
  parameter int PAD_MREG = 9
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  bf_mode_t mode,
  input  logic     mem_ack,
  output logic     take,
  output logic     rd_take,
  output logic     modify_en,
  output logic     finish,
  output logic     abort,
  output logic     busy,
  output logic     op_mem,
  output logic     mem_req,
  output logic     mem_we
);

  bf_state_e       st, nxt;
  logic [PADW-1:0] cnt;
  logic [PADW-1:0] pad_sel;
  logic            op_mem_q;
  logic            wr_ok_q;

  always_comb begin
    if (!mode.to_mem)    pad_sel = PADW'(PAD_REG);
    else if (mode.use_imm) pad_sel = PADW'(PAD_MIMM);
    else                 pad_sel = PADW'(PAD_MREG);
  end

  always_comb begin
    nxt     = st;
    take    = 1'b0;
    rd_take = 1'b0;
    finish  = 1'b0;
    abort   = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        nxt  = ST_WAIT;
        take = 1'b1;
      end
      ST_WAIT: if (cnt == '0) begin
        if (!op_mem_q) begin
          nxt    = ST_DONE;
          finish = 1'b1;
        end else if (!wr_ok_q) begin
          nxt   = ST_DONE;
          abort = 1'b1;
        end else begin
          nxt = ST_READ;
        end
      end
      ST_READ: if (mem_ack) begin
        nxt     = ST_MODIFY;
        rd_take = 1'b1;
      end
      ST_MODIFY: nxt = ST_WRITE;
      ST_WRITE: if (mem_ack) begin
        nxt    = ST_DONE;
        finish = 1'b1;
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      op_mem_q <= 1'b0;
      wr_ok_q  <= 1'b0;
    end else begin
      st <= nxt;
      if (take) begin
        cnt      <= pad_sel;
        op_mem_q <= mode.to_mem;
        wr_ok_q  <= mode.writable;
      end else if (st == ST_WAIT && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign busy      = (st != ST_IDLE);
  assign modify_en = (st == ST_MODIFY);
  assign op_mem    = op_mem_q;
  assign mem_req   = (st == ST_READ) || (st == ST_WRITE);
  assign mem_we    = (st == ST_WRITE);

  AST_REG_FORM_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    busy && !op_mem_q |-> !mem_req); // R3

  AST_FAULT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    busy && op_mem_q && !wr_ok_q |-> !mem_req); // R8

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> op_mem_q == $past(op_mem_q) && wr_ok_q == $past(wr_ok_q)); // R11

endmodule

// File: rtl/bitflip_unit.sv
module bitflip_unit
  import bitflip_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int LAT_REG  = 6,
  parameter int LAT_MIMM = 8,
  parameter int LAT_MREG = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          to_mem,
  input  logic          wide,
  input  logic          use_imm,
  input  logic [7:0]    imm_off,
  input  logic [DW-1:0] reg_off,
  input  logic [DW-1:0] reg_val,
  input  logic [AW-1:0] ea,
  input  logic          writable,
  output logic          busy,
  output logic          done,
  output logic          carry,
  output logic          fault,
  output logic [DW-1:0] result,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);

  localparam int POSW     = $clog2(DW);
  localparam int HALFW    = DW / 2;
  // pad = cycles spent in WAIT; memory path adds read, modify and write edges
  localparam int PAD_REG  = LAT_REG - 1;
  localparam int PAD_MIMM = LAT_MIMM - 4;
  localparam int PAD_MREG = LAT_MREG - 4;
  localparam int PAD_MAX  = (PAD_MREG > PAD_MIMM)
                          ? ((PAD_MREG > PAD_REG) ? PAD_MREG : PAD_REG)
                          : ((PAD_MIMM > PAD_REG) ? PAD_MIMM : PAD_REG);
  localparam int PADW     = $clog2(PAD_MAX + 1);

  bf_mode_t        mode;
  logic [POSW-1:0] loc_pos;
  logic [AW-1:0]   loc_addr;
  logic            take, rd_take, modify_en, finish, abort, op_mem;
  logic            old_bit;
  logic [DW-1:0]   flipped;

  logic [AW-1:0]   addr_q;
  logic [POSW-1:0] pos_q;
  logic            wide_q;
  logic [DW-1:0]   opnd_q;
  logic [DW-1:0]   wdata_q;
  logic            carry_q;
  logic [DW-1:0]   result_q;
  logic            done_q;
  logic            fault_q;

  assign mode = '{to_mem: to_mem, use_imm: use_imm, writable: writable};

  bitflip_locate #(.AW(AW), .DW(DW), .POSW(POSW)) u_locate (
    .wide    (wide),
    .use_imm (use_imm),
    .imm     (imm_off),
    .reg_off (reg_off),
    .ea      (ea),
    .bitpos  (loc_pos),
    .addr    (loc_addr)
  );

  bitflip_modify #(.DW(DW), .POSW(POSW)) u_modify (
    .word    (opnd_q),
    .bitpos  (pos_q),
    .old_bit (old_bit),
    .flipped (flipped)
  );

  bitflip_seq #(
    .PADW     (PADW),
    .PAD_REG  (PAD_REG),
    .PAD_MIMM (PAD_MIMM),
    .PAD_MREG (PAD_MREG)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mode      (mode),
    .mem_ack   (mem_ack),
    .take      (take),
    .rd_take   (rd_take),
    .modify_en (modify_en),
    .finish    (finish),
    .abort     (abort),
    .busy      (busy),
    .op_mem    (op_mem),
    .mem_req   (mem_req),
    .mem_we    (mem_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      pos_q    <= '0;
      wide_q   <= 1'b0;
      opnd_q   <= '0;
      wdata_q  <= '0;
      carry_q  <= 1'b0;
      result_q <= '0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      done_q  <= finish | abort;
      fault_q <= abort;
      if (take) begin
        addr_q <= loc_addr;
        pos_q  <= loc_pos;
        wide_q <= wide;
        opnd_q <= reg_val;
      end
      if (rd_take) begin
        opnd_q <= wide_q ? mem_rdata : {{HALFW{1'b0}}, mem_rdata[HALFW-1:0]};
      end
      if (modify_en) begin
        wdata_q <= flipped;
      end
      if (finish) begin
        carry_q <= old_bit;
        if (!op_mem) result_q <= flipped;
      end
    end
  end

  assign done      = done_q;
  assign fault     = fault_q;
  assign carry     = carry_q;
  assign result    = result_q;
  assign mem_addr  = addr_q;
  assign mem_wide  = wide_q;
  assign mem_wdata = wdata_q;

  AST_WDATA_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> $countones(mem_wdata ^ opnd_q) == 1); // R1

  AST_HALF_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy && !wide_q |-> !pos_q[POSW-1]); // R2

  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && !mem_wide |-> mem_wdata[DW-1:HALFW] == '0); // R7

  AST_FAULT_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    fault |-> done && carry == $past(carry)); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(addr_q) && $stable(pos_q)); // R11

endmodule

// File: tb/tb_bitflip_unit.sv
module tb_bitflip_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, to_mem = 1'b0, wide = 1'b0, use_imm = 1'b0, writable = 1'b0;
  logic [7:0]  imm_off = '0;
  logic [31:0] reg_off = '0, reg_val = '0, ea = '0;
  logic        busy, done, carry, fault, mem_req, mem_we, mem_wide;
  logic [31:0] result, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0, errors = 0;
  bit finished = 0;
  byte unsigned ram [256];
  byte unsigned model [256];
  int wait_cycles = 0;
  int rd_seen = 0, wr_seen = 0;
  logic [31:0] rd_addr_log, wr_addr_log, wr_data_log;
  logic rd_wide_log, wr_wide_log;
  bit hold_bad = 0;
  logic exp_carry = 1'b0;
  logic [31:0] exp_result = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitflip_unit dut (
    .clk(clk), .rst(rst), .start(start), .to_mem(to_mem), .wide(wide), .use_imm(use_imm),
    .imm_off(imm_off), .reg_off(reg_off), .reg_val(reg_val), .ea(ea), .writable(writable),
    .busy(busy), .done(done), .carry(carry), .fault(fault), .result(result),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // memory responder: acts at falling edges only
  initial begin
    int wc;
    logic [31:0] a0;
    wc = 0;
    a0 = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req === 1'b1) begin
        if (wc == 0) a0 = mem_addr;
        else if (mem_addr !== a0) hold_bad = 1;
        if (wc < wait_cycles) wc++;
        else begin
          wc = 0;
          mem_ack = 1'b1;
          if (mem_we) begin
            wr_seen++;
            wr_addr_log = mem_addr; wr_data_log = mem_wdata; wr_wide_log = mem_wide;
            for (int i = 0; i < (mem_wide ? 4 : 2); i++) ram[8'(mem_addr + i)] = mem_wdata[8*i +: 8];
          end else begin
            rd_seen++;
            rd_addr_log = mem_addr; rd_wide_log = mem_wide;
            mem_rdata = 32'hA5C3_0000;
            for (int i = 0; i < (mem_wide ? 4 : 2); i++) mem_rdata[8*i +: 8] = ram[8'(mem_addr + i)];
          end
        end
      end
    end
  end

  task automatic run_op(input bit m, input bit w, input bit ui, input logic [7:0] im,
                        input logic [31:0] ro, input logic [31:0] rv, input logic [31:0] e,
                        input bit wr, input int wt, input bit poke, input string atag);
    int off, sz, nb, q, pos, lat;
    logic [31:0] a, word, neww;
    bit fault_exp, c_exp;
    sz = w ? 32 : 16;
    nb = w ? 4 : 2;
    off = ui ? int'(im) % 32 : $signed(ro);
    q = off / sz;
    if (off < 0 && (off % sz) != 0) q--;
    pos = off - q * sz;
    a = e + 32'(q * nb);
    word = '0;
    if (m) for (int i = 0; i < nb; i++) word[8*i +: 8] = model[8'(a + i)];
    else word = rv;
    c_exp = word[pos];
    neww = word ^ (32'd1 << pos);
    fault_exp = m && !wr;
    if (!m) lat = 6;
    else if (fault_exp) lat = ui ? 5 : 10;
    else lat = (ui ? 8 : 13) + 2 * wt;

    @(negedge clk);
    to_mem = m; wide = w; use_imm = ui; imm_off = im; reg_off = ro; reg_val = rv;
    ea = e; writable = wr; start = 1'b1;
    wait_cycles = wt; rd_seen = 0; wr_seen = 0; hold_bad = 0;
    @(posedge clk);
    for (int k = 0; k <= lat + 1; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      if (poke && k == 1) begin start = 1'b1; imm_off = ~im; ea = e + 32'h40; to_mem = ~m; end
      if (poke && k == 2) start = 1'b0;
      check(done === (k == lat), $sformatf("R9 done at edge %0d (%s)", k, atag), done, k == lat);
      check(busy === (k <= lat), $sformatf("R11 busy at edge %0d", k), busy, k <= lat);
      if (k == lat) begin
        if (!fault_exp) begin
          exp_carry = c_exp;
          if (!m) exp_result = neww;
        end
        check(fault === fault_exp, "R8 fault flag", fault, fault_exp);
        check(carry === exp_carry, "R1 carry value", carry, exp_carry);
        check(result === exp_result, "R3 register result", result, exp_result);
      end
    end
    if (m && !fault_exp) begin
      for (int i = 0; i < nb; i++) model[8'(a + i)] = neww[8*i +: 8];
      check(rd_seen == 1 && wr_seen == 1, "R7 one read one write", {rd_seen[15:0], wr_seen[15:0]}, 32'h0001_0001);
      check(rd_addr_log === a, {atag, " read address"}, rd_addr_log, a);
      check(wr_addr_log === a, {atag, " write address"}, wr_addr_log, a);
      check(rd_wide_log === w && wr_wide_log === w, "R7 access size", {rd_wide_log, wr_wide_log}, {w, w});
      if (!w) check(wr_data_log[31:16] === 16'h0, "R7 upper half of 2-byte write", wr_data_log[31:16], 0);
      check(!hold_bad, "R10 address held while waiting", hold_bad, 0);
    end else begin
      check(rd_seen == 0 && wr_seen == 0, m ? "R8 no bus traffic on fault" : "R3 no bus traffic",
            rd_seen + wr_seen, 0);
    end
    for (int i = 0; i < 4; i++)
      check(ram[8'(a + i)] === model[8'(a + i)], "R1 memory contents", ram[8'(a + i)], model[8'(a + i)]);
    if (poke) begin
      repeat (3) begin
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R11 ignored start launched nothing", {busy, done}, 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = 8'(i * 37 + 5);
      model[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy === 0 && done === 0 && fault === 0 && carry === 0 && mem_req === 0,
          "R12 reset outputs", {busy, done, fault, carry, mem_req}, 0);
    check(result === 32'h0, "R12 reset result", result, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 0 && mem_req === 0, "R12 idle after reset", {busy, mem_req}, 0);

    // register form (R2, R3)
    run_op(0, 1, 1, 8'hE5, 0, 32'h0000_0020, 0, 1, 0, 0, "R2");
    run_op(0, 0, 1, 8'h3B, 0, 32'hFFFF_0000, 0, 1, 0, 0, "R2");
    run_op(0, 1, 0, 8'h00, 32'hFFFF_FFE3, 32'h0000_0008, 0, 1, 0, 0, "R3");
    // memory, immediate offsets (R4, R5)
    run_op(1, 1, 1, 8'h47, 0, 0, 32'h0000_1040, 1, 0, 0, "R4");
    run_op(1, 0, 1, 8'h1C, 0, 0, 32'h0000_1050, 1, 0, 0, "R5");
    // memory, register offsets with stalls (R4, R6, R9)
    run_op(1, 1, 0, 8'h00, 32'd100, 0, 32'h0000_1060, 1, 2, 0, "R4");
    run_op(1, 0, 0, 8'h00, -32'sd40, 0, 32'h0000_1080, 1, 0, 0, "R6");
    run_op(1, 1, 0, 8'h00, -32'sd1, 0, 32'h0000_10A0, 1, 1, 0, "R6");
    // repeat restores the operand (R1)
    run_op(1, 1, 1, 8'h47, 0, 0, 32'h0000_1040, 1, 0, 0, "R4");
    // protection faults (R8)
    run_op(1, 1, 1, 8'h03, 0, 0, 32'h0000_10C0, 0, 0, 0, "R8");
    run_op(1, 0, 0, 8'h00, -32'sd20, 0, 32'h0000_10D0, 0, 0, 0, "R8");
    // start while busy (R11)
    run_op(0, 1, 1, 8'h1F, 0, 32'h8000_0001, 0, 1, 0, 1, "R11");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule